// File: doc/BRIEF.md
# Coin-credit vending controller

This controller sits between a coin acceptor, two selection buttons and two dispensing mechanisms. Each clock cycle it samples four strobes: a five-cent coin, a ten-cent coin, a candy request and a soda request. At most one of these is expected per cycle. The controller keeps a running credit in five-cent steps, with a ceiling of fifteen cents. It shows the credit in cents on a 4-bit unsigned output.

A candy sale needs ten cents and a soda sale needs fifteen cents. Both products draw on the same credit. The vend outputs are Mealy outputs: a vend pulse is high in the same cycle as a request that the current credit can pay for, and the price is taken off the credit at the next clock edge. A coin that would push the credit past fifteen cents is kept, and no change is given. A request that the credit cannot cover does nothing. Cycles with no strobe leave the credit as it is.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the credit goes to 0. After that edge, `credit_cents_o` reads 0, and with no strobes asserted both vend outputs read 0.
- R2: A cycle in which `nickel_i` is the only asserted strobe raises the credit by 5 cents at the next edge. The result is capped at 15.
- R3: A cycle in which `dime_i` is the only asserted strobe raises the credit by 10 cents at the next edge. The result is capped at 15, and the excess is kept without change.
- R4: When `candy_req_i` is the only asserted strobe and the credit is at least 10 cents, `candy_vend_o` is 1 in that same cycle. The credit drops by 10 at the next edge.
- R5: When `soda_req_i` is the only asserted strobe and the credit is 15 cents, `soda_vend_o` is 1 in that same cycle. The credit becomes 0 at the next edge.
- R6: A request that the current credit cannot pay for keeps both vend outputs at 0 and leaves the credit unchanged.
- R7: A cycle with no strobe asserted leaves the credit unchanged and keeps both vend outputs at 0.
- R8: `credit_cents_o` only takes the values 0, 5, 10 and 15.
- R9: A cycle with two or more strobes asserted has no effect. Both vend outputs stay at 0 and the credit is unchanged.
- R10: `candy_vend_o` is never high unless `candy_req_i` is high, and `soda_vend_o` is never high unless `soda_req_i` is high. The two vend outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dime_i | input | 1 | Ten-cent coin accepted this cycle |
| nickel_i | input | 1 | Five-cent coin accepted this cycle |
| candy_req_i | input | 1 | Candy button pressed this cycle |
| soda_req_i | input | 1 | Soda button pressed this cycle |
| candy_vend_o | output | 1 | Release one candy (same-cycle response to the request) |
| soda_vend_o | output | 1 | Release one soda (same-cycle response to the request) |
| credit_cents_o | output | 4 | Current credit in cents, unsigned |

## Verification
All of the block's memory is the credit register, and that register drives `credit_cents_o` directly. A wrong credit value therefore shows on the port one edge after the stimulus that caused it. A wrong credit also shows in the same cycle as the next request: the vend decision is made from that credit, so a candy or soda request exposes it. The bench sets up every reachable credit, applies every one of the 16 strobe patterns to each, and compares the same-cycle vend outputs and the next-cycle credit against a cents model. A long pseudo-random run then checks that errors do not build up over many steps.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [2:0] {
        EV_IDLE   = 3'd0,
        EV_NICKEL = 3'd1,
        EV_DIME   = 3'd2,
        EV_CANDY  = 3'd3,
        EV_SODA   = 3'd4
    } vend_ev_e;

endpackage

// File: rtl/vend_req_decode.sv
module vend_req_decode
    import vend_pkg::*;
(
    input  logic     dime_i,
    input  logic     nickel_i,
    input  logic     candy_i,
    input  logic     soda_i,
    output vend_ev_e ev_o
);
    logic [3:0] strb;

    always_comb begin
        strb = {dime_i, nickel_i, candy_i, soda_i};
        ev_o = EV_IDLE;
        // Only a single strobe is a legal event; anything else is ignored (R9)
        if ($onehot(strb)) begin
            if (dime_i)        ev_o = EV_DIME;
            else if (nickel_i) ev_o = EV_NICKEL;
            else if (candy_i)  ev_o = EV_CANDY;
            else               ev_o = EV_SODA;
        end
    end
endmodule

// File: rtl/vend_credit_step.sv
module vend_credit_step
    import vend_pkg::*;
#(
    parameter int unsigned CAP_UNITS    = 3,
    parameter int unsigned NICKEL_UNITS = 1,
    parameter int unsigned DIME_UNITS   = 2,
    parameter int unsigned CANDY_UNITS  = 2,
    parameter int unsigned SODA_UNITS   = 3,
    localparam int unsigned UNIT_W      = $clog2(CAP_UNITS + 1),
    localparam int unsigned SUM_W       = $clog2(CAP_UNITS + NICKEL_UNITS + DIME_UNITS + 1)
) (
    input  logic [UNIT_W-1:0] units_i,
    input  vend_ev_e          ev_i,
    output logic [UNIT_W-1:0] units_o,
    output logic              candy_o,
    output logic              soda_o
);
    typedef struct packed {
        logic [UNIT_W-1:0] units;
        logic              candy;
        logic              soda;
    } step_t;

    step_t             step_d;
    logic [SUM_W-1:0]  add_v;
    logic [SUM_W-1:0]  sum_v;

    always_comb begin
        step_d       = '{units: units_i, candy: 1'b0, soda: 1'b0};
        add_v        = '0;
        unique case (ev_i)
            EV_NICKEL: add_v = SUM_W'(NICKEL_UNITS);
            EV_DIME:   add_v = SUM_W'(DIME_UNITS);
            default:   add_v = '0;
        endcase
        sum_v = SUM_W'(units_i) + add_v;

        unique case (ev_i)
            EV_NICKEL, EV_DIME: begin
                // Coins past the ceiling are absorbed without change
                if (sum_v > SUM_W'(CAP_UNITS)) step_d.units = UNIT_W'(CAP_UNITS);
                else                           step_d.units = UNIT_W'(sum_v);
            end
            EV_CANDY: begin
                if (units_i >= UNIT_W'(CANDY_UNITS)) begin
                    step_d.candy = 1'b1;
                    step_d.units = units_i - UNIT_W'(CANDY_UNITS);
                end
            end
            EV_SODA: begin
                if (units_i >= UNIT_W'(SODA_UNITS)) begin
                    step_d.soda  = 1'b1;
                    step_d.units = units_i - UNIT_W'(SODA_UNITS);
                end
            end
            default: ;
        endcase
    end

    assign units_o = step_d.units;
    assign candy_o = step_d.candy;
    assign soda_o  = step_d.soda;
endmodule

// File: rtl/vend_credit_scale.sv
module vend_credit_scale #(
    parameter int unsigned UNIT_W     = 2,
    parameter int unsigned UNIT_CENTS = 5,
    parameter int unsigned CENT_W     = 4
) (
    input  logic [UNIT_W-1:0] units_i,
    output logic [CENT_W-1:0] cents_o
);
    localparam int unsigned SHIFT = $clog2(UNIT_CENTS);

    generate
        if ((1 << SHIFT) == UNIT_CENTS) begin : g_shift
            assign cents_o = CENT_W'(units_i) << SHIFT;
        end else begin : g_mult
            assign cents_o = CENT_W'(units_i * UNIT_CENTS);
        end
    endgenerate
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import vend_pkg::*;
#(
    parameter int unsigned UNIT_CENTS   = 5,
    parameter int unsigned CAP_UNITS    = 3,
    parameter int unsigned NICKEL_UNITS = 1,
    parameter int unsigned DIME_UNITS   = 2,
    parameter int unsigned CANDY_UNITS  = 2,
    parameter int unsigned SODA_UNITS   = 3,
    parameter int unsigned CENT_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dime_i,
    input  logic              nickel_i,
    input  logic              candy_req_i,
    input  logic              soda_req_i,
    output logic              candy_vend_o,
    output logic              soda_vend_o,
    output logic [CENT_W-1:0] credit_cents_o
);
    localparam int unsigned UNIT_W       = $clog2(CAP_UNITS + 1);
    localparam int unsigned CAP_CENTS    = CAP_UNITS * UNIT_CENTS;
    localparam int unsigned NICKEL_CENTS = NICKEL_UNITS * UNIT_CENTS;
    localparam int unsigned DIME_CENTS   = DIME_UNITS * UNIT_CENTS;
    localparam int unsigned CANDY_CENTS  = CANDY_UNITS * UNIT_CENTS;
    localparam int unsigned SODA_CENTS   = SODA_UNITS * UNIT_CENTS;

    typedef struct packed {
        logic [UNIT_W-1:0] units;
    } state_t;

    state_t            state_d, state_q;
    vend_ev_e          ev;
    logic [UNIT_W-1:0] units_nx;
    logic              candy_nx, soda_nx;

    vend_req_decode u_decode (
        .dime_i   (dime_i),
        .nickel_i (nickel_i),
        .candy_i  (candy_req_i),
        .soda_i   (soda_req_i),
        .ev_o     (ev)
    );

    vend_credit_step #(
        .CAP_UNITS    (CAP_UNITS),
        .NICKEL_UNITS (NICKEL_UNITS),
        .DIME_UNITS   (DIME_UNITS),
        .CANDY_UNITS  (CANDY_UNITS),
        .SODA_UNITS   (SODA_UNITS)
    ) u_step (
        .units_i (state_q.units),
        .ev_i    (ev),
        .units_o (units_nx),
        .candy_o (candy_nx),
        .soda_o  (soda_nx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.units = units_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign candy_vend_o = candy_nx;
    assign soda_vend_o  = soda_nx;

    vend_credit_scale #(
        .UNIT_W     (UNIT_W),
        .UNIT_CENTS (UNIT_CENTS),
        .CENT_W     (CENT_W)
    ) u_scale (
        .units_i (state_q.units),
        .cents_o (credit_cents_o)
    );

    // ---------------- assertions ----------------
    logic only_n, only_d, only_c, only_s, none_on, multi_on;
    always_comb begin
        none_on  = !(dime_i || nickel_i || candy_req_i || soda_req_i);
        multi_on = $countones({dime_i, nickel_i, candy_req_i, soda_req_i}) > 1;
        only_n   = nickel_i    && !dime_i && !candy_req_i && !soda_req_i;
        only_d   = dime_i      && !nickel_i && !candy_req_i && !soda_req_i;
        only_c   = candy_req_i && !dime_i && !nickel_i && !soda_req_i;
        only_s   = soda_req_i  && !dime_i && !nickel_i && !candy_req_i;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> credit_cents_o == '0);

    assert_nickel_add_R2: assert property (@(posedge clk) disable iff (rst)
        only_n |=> (int'(credit_cents_o) ==
            ((int'($past(credit_cents_o)) + NICKEL_CENTS > CAP_CENTS) ? CAP_CENTS
                : int'($past(credit_cents_o)) + NICKEL_CENTS)));

    assert_dime_add_R3: assert property (@(posedge clk) disable iff (rst)
        only_d |=> (int'(credit_cents_o) ==
            ((int'($past(credit_cents_o)) + DIME_CENTS > CAP_CENTS) ? CAP_CENTS
                : int'($past(credit_cents_o)) + DIME_CENTS)));

    assert_candy_sale_R4: assert property (@(posedge clk) disable iff (rst)
        (only_c && int'(credit_cents_o) >= CANDY_CENTS) |-> candy_vend_o);

    assert_candy_debit_R4: assert property (@(posedge clk) disable iff (rst)
        candy_vend_o |=> int'(credit_cents_o) == int'($past(credit_cents_o)) - CANDY_CENTS);

    assert_soda_sale_R5: assert property (@(posedge clk) disable iff (rst)
        (only_s && int'(credit_cents_o) >= SODA_CENTS) |-> soda_vend_o);

    assert_soda_debit_R5: assert property (@(posedge clk) disable iff (rst)
        soda_vend_o |=> int'(credit_cents_o) == int'($past(credit_cents_o)) - SODA_CENTS);

    assert_short_credit_R6: assert property (@(posedge clk) disable iff (rst)
        ((only_c && int'(credit_cents_o) < CANDY_CENTS) ||
         (only_s && int'(credit_cents_o) < SODA_CENTS))
            |-> (!candy_vend_o && !soda_vend_o) ##1 $stable(credit_cents_o));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        none_on |=> $stable(credit_cents_o));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        int'(credit_cents_o) <= CAP_CENTS && (int'(credit_cents_o) % UNIT_CENTS) == 0);

    assert_multi_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        multi_on |-> (!candy_vend_o && !soda_vend_o) ##1 $stable(credit_cents_o));

    assert_vend_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({candy_vend_o, soda_vend_o}) <= 1 &&
        (!candy_vend_o || candy_req_i) && (!soda_vend_o || soda_req_i));
endmodule

// File: tb/tb_coin_vend_ctrl.sv
module tb_coin_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dime_i = 1'b0, nickel_i = 1'b0, candy_req_i = 1'b0, soda_req_i = 1'b0;
    logic       candy_vend_o, soda_vend_o;
    logic [3:0] credit_cents_o;

    int tests = 0;
    int fails = 0;
    int model_cr = 0;

    always #2 clk = ~clk;

    coin_vend_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .dime_i         (dime_i),
        .nickel_i       (nickel_i),
        .candy_req_i    (candy_req_i),
        .soda_req_i     (soda_req_i),
        .candy_vend_o   (candy_vend_o),
        .soda_vend_o    (soda_vend_o),
        .credit_cents_o (credit_cents_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [3:0] p, input int cr);
        if ($countones(p) > 1) return "R9";
        if (p == 4'b0000)      return "R7";
        if (p[3])              return "R3";
        if (p[2])              return "R2";
        if (p[1])              return (cr >= 10) ? "R4" : "R6";
        return (cr >= 15) ? "R5" : "R6";
    endfunction

    // pattern bits: [3]=dime [2]=nickel [1]=candy [0]=soda
    task automatic step(input logic [3:0] p);
        int exp_dc = 0, exp_ds = 0, nxt = model_cr;
        string tg = tag_for(p, model_cr);
        if ($countones(p) == 1) begin
            if (p[3]) nxt = (model_cr + 10 > 15) ? 15 : model_cr + 10;
            if (p[2]) nxt = (model_cr + 5 > 15) ? 15 : model_cr + 5;
            if (p[1] && model_cr >= 10) begin exp_dc = 1; nxt = model_cr - 10; end
            if (p[0] && model_cr >= 15) begin exp_ds = 1; nxt = model_cr - 15; end
        end
        @(negedge clk);
        {dime_i, nickel_i, candy_req_i, soda_req_i} = p;
        #1;
        check(tg, "candy_vend", int'(candy_vend_o), exp_dc);
        check(exp_ds ? "R5" : "R10", "soda_vend", int'(soda_vend_o), exp_ds);
        @(posedge clk);
        #1;
        {dime_i, nickel_i, candy_req_i, soda_req_i} = 4'b0000;
        model_cr = nxt;
        check(tg, "credit", int'(credit_cents_o), model_cr);
        check("R8", "credit grid", int'(credit_cents_o % 5 == 0 && credit_cents_o <= 15), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_cr = 0;
        check("R1", "credit after reset", int'(credit_cents_o), 0);
        check("R1", "candy_vend idle", int'(candy_vend_o), 0);
        check("R1", "soda_vend idle", int'(soda_vend_o), 0);
    endtask

    initial begin
        #400000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        // Exhaustive: every start credit crossed with every strobe pattern
        for (int start = 0; start < 4; start++) begin
            for (int pat = 0; pat < 16; pat++) begin
                do_reset();
                for (int k = 0; k < start; k++) step(4'b0100);
                step(4'(pat));
            end
        end
        // Reset while credit is held at the ceiling (R1)
        step(4'b1000); step(4'b1000);
        do_reset();
        // Pseudo-random single-strobe and idle sequence
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [3:0] p;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd5: p = 4'b0100;
                3'd1:       p = 4'b1000;
                3'd2, 3'd6: p = 4'b0010;
                3'd3:       p = 4'b0001;
                default:    p = (lfsr[7:4] == 4'hF) ? 4'b1010 : 4'b0000;
            endcase
            step(p);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule